// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a registered/combinatorial programmable logic device. It receives a sum-of-products data term that the logic array has already evaluated and turns it into the value driven onto one bidirectional pin. It also produces the enable for that pin's tri-state driver and a feedback bit that goes back into the array. Two static configuration bits set the cell up. One picks registered or combinatorial operation. The other picks whether the output is active-high or active-low.

In registered mode the data term is captured by a flip-flop on each rising clock edge. The flip-flop has three controls, listed here from highest priority to lowest:
- an asynchronous clear term, which acts at once without waiting for a clock edge;
- a test preload path, which loads the pin value into the register while the pin drivers are forced off;
- a synchronous set term.

Polarity inversion sits after the flip-flop. So set, clear and preload all act on the stored state, and the pin shows that state through the selected polarity. The chip-level power-on reset (`rst_n`) clears the register. It asserts asynchronously and is released on a clock edge through a short synchronizer.

In combinatorial mode the data term passes straight to the polarity stage. The pin is read back as feedback. Holding the enable term low turns the cell into a dedicated input.

Top module: `pld_macrocell`

## Requirements
- R1: With `test_load` low, `pin_oe` equals `oe_term` at all times.
- R2: While `test_load` is high, `pin_oe` is 0 whatever `oe_term` is.
- R3: `pin_drv` is the internal output value (the register in registered mode, `sop_term` in combinatorial mode) when `cfg_act_high` is 1, and its inverse when `cfg_act_high` is 0. This holds in both modes.
- R4: In registered mode (`cfg_reg_mode` = 1), when every control term is low, a rising clock edge loads `sop_term` into the register.
- R5: When `set_term` is high and neither `clr_term` nor `test_load` is high, the register holds 1 after the next rising clock edge, whatever `sop_term` is.
- R6: When `clr_term` goes high, the register becomes 0 without a clock edge. It stays 0 across clock edges while `clr_term` is high, even when `set_term` or `test_load` is also high.
- R7: While `rst_n` is low and after it is released, the register is 0. `pin_drv` is then 0 for active-high and 1 for active-low.
- R8: When `test_load` is high and `clr_term` is low, a rising clock edge loads `pin_in` into the register. This overrides both `set_term` and `sop_term`.
- R9: In combinatorial mode, `pin_drv` follows `sop_term` through the polarity stage with no clock edge, and `fb_out` equals `pin_in`.
- R10: In registered mode, `fb_out` is the register's true value and does not depend on `cfg_act_high`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, rising edge active |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cfg_reg_mode | input | 1 | 1 = registered mode, 0 = combinatorial mode |
| cfg_act_high | input | 1 | 1 = active-high output, 0 = active-low output |
| sop_term | input | 1 | Evaluated sum-of-products data term |
| oe_term | input | 1 | Output-enable product term |
| set_term | input | 1 | Synchronous set product term |
| clr_term | input | 1 | Asynchronous clear product term |
| test_load | input | 1 | Test preload enable |
| pin_in | input | 1 | Value currently present on the pin |
| pin_drv | output | 1 | Value to drive onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the logic array |

## Verification
The register properties assume a few things about the inputs:
- the control terms, the data term and `pin_in` change only away from the rising edge;
- a clear pulse is never raised and dropped between two edges straight after a set or preload edge;
- the configuration bits are static while the register is being checked.

The stimulus meets these assumptions. It changes every input on the falling edge, it samples shortly after one edge or the other, and it changes the mode or polarity only between check groups. The clear term is raised at a falling edge and held through at least one rising edge. This lets the bench check both the immediate clear and the priority of clear over set and preload.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic {
    MODE_COMB = 1'b0,
    MODE_REG  = 1'b1
  } mc_mode_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } mc_pol_e;

  typedef enum logic [1:0] {
    SRC_DATA    = 2'd0,
    SRC_SET     = 2'd1,
    SRC_PRELOAD = 2'd2
  } mc_src_e;

  typedef struct packed {
    mc_mode_e mode;
    mc_pol_e  pol;
  } mc_cfg_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import pld_mc_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic data_in,
  input  logic set_in,
  input  logic clr_in,
  input  logic load_en,
  input  logic load_val,
  output logic state_q
);

  mc_src_e src_sel;
  logic    state_d;
  logic    cap_en;
  logic    armed_q;

  // Next-state selection: preload outranks set, set outranks data
  always_comb begin
    if (load_en)     src_sel = SRC_PRELOAD;
    else if (set_in) src_sel = SRC_SET;
    else             src_sel = SRC_DATA;
  end

  always_comb begin
    unique case (src_sel)
      SRC_PRELOAD: state_d = load_val;
      SRC_SET:     state_d = 1'b1;
      default:     state_d = data_in;
    endcase
  end

  // The cell captures on every edge; the enable is kept explicit
  assign cap_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n or posedge clr_in) begin
    if (!rst_sync_n)  state_q <= 1'b0;
    else if (clr_in)  state_q <= 1'b0;
    else if (cap_en)  state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= 1'b1;
  end

  // R6
  clr_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_in |-> (state_q == 1'b0));

  // R5
  set_loads_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && set_in && !clr_in && !load_en) |=> (state_q || clr_in));

  // R8
  preload_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && load_en && !clr_in) |=> ((state_q == $past(load_val)) || clr_in));

  // R4
  data_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && !load_en && !set_in && !clr_in) |=>
      ((state_q == $past(data_in)) || clr_in));

endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage
  import pld_mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_sync_n,
  input  mc_cfg_t cfg,
  input  logic    data_in,
  input  logic    state_q,
  input  logic    oe_in,
  input  logic    load_en,
  input  logic    pin_val,
  output logic    drv_out,
  output logic    drv_en,
  output logic    fb
);

  logic core_val;

  generate
    begin : g_path
      always_comb begin
        core_val = (cfg.mode == MODE_REG) ? state_q : data_in;
        drv_out  = (cfg.pol == POL_HIGH) ? core_val : ~core_val;
        drv_en   = oe_in & ~load_en;
        fb       = (cfg.mode == MODE_REG) ? state_q : pin_val;
      end
    end
  endgenerate

  // R3, R10: in registered mode the pin is the feedback seen through polarity
  reg_pin_matches_fb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg.mode == MODE_REG) |-> (drv_out == (fb ^ (cfg.pol == POL_LOW))));

  // R9
  comb_fb_from_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg.mode == MODE_COMB) |-> (fb == pin_val));

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_reg_mode,
  input  logic cfg_act_high,
  input  logic sop_term,
  input  logic oe_term,
  input  logic set_term,
  input  logic clr_term,
  input  logic test_load,
  input  logic pin_in,
  output logic pin_drv,
  output logic pin_oe,
  output logic fb_out
);

  logic    rst_sync_n;
  logic    state_q;
  mc_cfg_t cfg;

  assign cfg.mode = mc_mode_e'(cfg_reg_mode);
  assign cfg.pol  = mc_pol_e'(cfg_act_high);

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mc_state_reg u_state (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .data_in    (sop_term),
    .set_in     (set_term),
    .clr_in     (clr_term),
    .load_en    (test_load),
    .load_val   (pin_in),
    .state_q    (state_q)
  );

  mc_out_stage u_out (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cfg        (cfg),
    .data_in    (sop_term),
    .state_q    (state_q),
    .oe_in      (oe_term),
    .load_en    (test_load),
    .pin_val    (pin_in),
    .drv_out    (pin_drv),
    .drv_en     (pin_oe),
    .fb         (fb_out)
  );

  // R2
  preload_drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_load |-> !pin_oe);

  // R1
  oe_follows_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_load |-> (pin_oe == oe_term));

endmodule

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;

  typedef struct {
    logic  exp_drv;
    logic  exp_oe;
    logic  exp_fb;
    string tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_reg_mode, cfg_act_high, sop_term, oe_term;
  logic set_term, clr_term, test_load, pin_in;
  logic pin_drv, pin_oe, fb_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  sb_item_t sb[$];

  always #5 clk = ~clk;

  pld_macrocell u_pld_macrocell (
    .clk(clk), .rst_n(rst_n), .cfg_reg_mode(cfg_reg_mode),
    .cfg_act_high(cfg_act_high), .sop_term(sop_term), .oe_term(oe_term),
    .set_term(set_term), .clr_term(clr_term), .test_load(test_load),
    .pin_in(pin_in), .pin_drv(pin_drv), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  // Driver side: queue what the outputs should be right now
  task automatic expect_now(input logic d, input logic o, input logic f,
                            input string tag);
    sb_item_t it;
    it.exp_drv = d; it.exp_oe = o; it.exp_fb = f; it.tag = tag;
    sb.push_back(it);
    #1;
  endtask

  task automatic at_fall();
    @(negedge clk);
  endtask

  task automatic after_rise();
    @(posedge clk);
    #2;
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      sb_item_t it;
      wait (sb.size() != 0);
      it = sb.pop_front();
      checks++;
      if (pin_drv !== it.exp_drv || pin_oe !== it.exp_oe || fb_out !== it.exp_fb) begin
        fails++;
        $display("FAIL %s: drv/oe/fb actual %b%b%b expected %b%b%b", it.tag,
                 pin_drv, pin_oe, fb_out, it.exp_drv, it.exp_oe, it.exp_fb);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_reg_mode = 1'b1; cfg_act_high = 1'b1; sop_term = 1'b0;
    oe_term = 1'b1; set_term = 1'b0; clr_term = 1'b0; test_load = 1'b0; pin_in = 1'b0;
    repeat (3) after_rise();
    // R7 reset state, both polarities
    expect_now(1'b0, 1'b1, 1'b0, "R7 reset active-high");
    cfg_act_high = 1'b0; #2;
    expect_now(1'b1, 1'b1, 1'b0, "R7 reset active-low");
    cfg_act_high = 1'b1;
    at_fall(); rst_n = 1'b1;
    repeat (4) after_rise();
    expect_now(1'b0, 1'b1, 1'b0, "R7 after release");

    // R4 capture on edge only
    at_fall(); sop_term = 1'b1; #2;
    expect_now(1'b0, 1'b1, 1'b0, "R4 no change before edge");
    after_rise();
    expect_now(1'b1, 1'b1, 1'b1, "R4 captured 1");

    // R3 / R10 polarity after the register
    at_fall(); cfg_act_high = 1'b0; #2;
    expect_now(1'b0, 1'b1, 1'b1, "R3 R10 active-low register 1");
    at_fall(); sop_term = 1'b0;
    after_rise();
    expect_now(1'b1, 1'b1, 1'b0, "R4 captured 0 active-low");

    // R5 set overrides data
    at_fall(); set_term = 1'b1;
    after_rise();
    expect_now(1'b0, 1'b1, 1'b1, "R5 set to 1");

    // R6 immediate clear, priority over set
    at_fall(); clr_term = 1'b1; #2;
    expect_now(1'b1, 1'b1, 1'b0, "R6 immediate clear");
    after_rise();
    expect_now(1'b1, 1'b1, 1'b0, "R6 clear beats set");
    at_fall(); clr_term = 1'b0; set_term = 1'b0; cfg_act_high = 1'b1;

    // R8 preload with drivers off (R2)
    at_fall(); test_load = 1'b1; pin_in = 1'b1; #2;
    expect_now(1'b0, 1'b0, 1'b0, "R2 preload disables driver");
    after_rise();
    expect_now(1'b1, 1'b0, 1'b1, "R8 preload loads 1");
    at_fall(); set_term = 1'b1; sop_term = 1'b1; pin_in = 1'b0;
    after_rise();
    expect_now(1'b0, 1'b0, 1'b0, "R8 preload beats set and data");
    at_fall(); set_term = 1'b0; sop_term = 1'b0; pin_in = 1'b1; clr_term = 1'b1;
    after_rise();
    expect_now(1'b0, 1'b0, 1'b0, "R6 clear beats preload");
    at_fall(); clr_term = 1'b0; test_load = 1'b0; pin_in = 1'b0;

    // R1 enable follows term
    at_fall(); oe_term = 1'b0; #2;
    expect_now(1'b0, 1'b0, 1'b0, "R1 enable low");
    at_fall(); oe_term = 1'b1; #2;
    expect_now(1'b0, 1'b1, 1'b0, "R1 enable high");

    // R9 combinatorial mode
    at_fall(); cfg_reg_mode = 1'b0; sop_term = 1'b1; pin_in = 1'b1; #2;
    expect_now(1'b1, 1'b1, 1'b1, "R9 comb active-high");
    pin_in = 1'b0; #2;
    expect_now(1'b1, 1'b1, 1'b0, "R9 fb from pin");
    cfg_act_high = 1'b0; #2;
    expect_now(1'b0, 1'b1, 1'b0, "R3 R9 comb active-low");
    sop_term = 1'b0; #2;
    expect_now(1'b1, 1'b1, 1'b0, "R9 comb follows data");
    at_fall(); oe_term = 1'b0; pin_in = 1'b1; #2;
    expect_now(1'b1, 1'b0, 1'b1, "R1 R9 dedicated input");

    #5;
    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule